// File: doc/BRIEF.md
# Host Bridge Address Window Decoder

This block keeps the configuration of the address windows that a host bridge uses to decide which requests go to its graphics port, and it classifies each incoming request against them. It has two memory windows, one plain and one prefetchable, and one I/O window. Each of these is a base/limit pair with coarse granularity. It also has a graphics aperture, which is set by an aligned base and a power-of-two size code. A control register holds the port enable, the sideband enable and the transfer-rate selection.

A request is presented as an address, a memory/I/O flag and a one-cycle strobe. One clock later the block shows which windows matched. It also shows whether the request is forwarded to the graphics port, which happens only while the port is enabled. Forwarded work is tracked by a single pending flag. That flag stays set after the port is disabled, and it clears only when the servicing side reports completion. Configuration is written through a simple select/data port and can be read back combinationally.

Top module: `addr_win_decoder`

## Requirements
- R1: The plain memory window register (select 1) holds the base in bits [11:0] and the limit in bits [27:16]. A memory request hits when address bits [31:20] lie between base and limit inclusive, which gives 1 MB alignment and granularity. After reset the base is FFFh and the limit is 000h.
- R2: The prefetchable memory window register (select 2) has the same layout as select 1 and is decoded the same way, independently of the plain window.
- R3: The I/O window register (select 3) holds the base in bits [3:0] and the limit in bits [11:8]. An I/O request hits when address bits [15:12] lie between base and limit inclusive, which gives 4 KB granularity. After reset the base is Fh and the limit is 0h.
- R4: A base/limit window whose base is greater than its limit never hits, at any address.
- R5: The aperture register (select 4) holds the base in bits [31:22] and the size code in bits [2:0]. Code n selects a size of 4 MB shifted left by n, for n from 0 to 6 (4 to 256 MB). A memory request hits when its address bits above the size boundary equal the same bits of the base. After reset the base is 3FFh and the code is 0.
- R6: When the aperture register is written with size code 7, the size field keeps its old value, while the base field still updates.
- R7: The outputs hit_mem, hit_pmem, hit_io and hit_aper are valid in the clock cycle after the request strobe and are 0 in a cycle that follows no strobe. The memory windows and the aperture respond only when req_is_io is 0. The I/O window responds only when req_is_io is 1.
- R8: The control register (select 0) holds the transfer rate in bits [1:0] (01 means 1x, 10 means 2x), port enable in bit 8 and sideband enable in bit 9. After reset it reads 0000_0001h. The reserved bits read 0, and unused selects 5 to 7 read 0.
- R9: A control write whose rate field is 00 or 11 leaves the rate unchanged, while bits 8 and 9 still update.
- R10: fwd_gfx is 1 in the cycle after a strobe only when port enable was 1 and at least one window hit. Hit flags are reported whatever the enable.
- R11: op_pend is set by every forwarded request and cleared by svc_done. When both happen in the same cycle, setting wins. Clearing port enable does not clear op_pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 3 | Register select for readback |
| cfg_rdata | output | 32 | Readback data (combinational) |
| req_vld | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| svc_done | input | 1 | Pending forwarded work has completed |
| hit_mem | output | 1 | Plain memory window hit |
| hit_pmem | output | 1 | Prefetchable memory window hit |
| hit_io | output | 1 | I/O window hit |
| hit_aper | output | 1 | Graphics aperture hit |
| fwd_gfx | output | 1 | Request forwarded to the graphics port |
| op_pend | output | 1 | Forwarded work outstanding |

## Verification
A corrupted base, limit or size field shows up on the hit flag of its own window exactly one cycle after the first request that probes the affected boundary. For that reason, each window is probed on both sides of its lower and upper edges. A wrong control field appears at once on readback and then on fwd_gfx at the next strobe. A pending flag that is lost or stuck shows up in the cycle after the enable change or the completion pulse that should, or should not, have moved it.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W       = 32;
  localparam int DATA_W       = 32;
  localparam int SEL_W        = 3;
  localparam int MEM_KEY_W    = 12;
  localparam int IO_SPACE_W   = 16;
  localparam int IO_KEY_W     = 4;
  localparam int APER_KEY_W   = 10;
  localparam int SIZE_CODE_W  = 3;
  localparam int SIZE_CODE_MAX = 6;
  localparam int RATE_W       = 2;
  localparam int N_MEM_WIN    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_MEM  = 3'd1,
    SEL_PMEM = 3'd2,
    SEL_IO   = 3'd3,
    SEL_APER = 3'd4
  } cfg_sel_e;

  // Bits of the aperture key that take part in the match for a size code.
  function automatic logic [APER_KEY_W-1:0] aper_keep_mask(
    input logic [SIZE_CODE_W-1:0] code
  );
    logic [APER_KEY_W-1:0] m;
    m = '1;
    for (int i = 0; i < APER_KEY_W; i++) begin
      if (i < int'(code)) m[i] = 1'b0;
    end
    return m;
  endfunction

  function automatic logic rate_valid(input logic [RATE_W-1:0] r);
    return (r == 2'b01) || (r == 2'b10);
  endfunction

  function automatic logic size_code_valid(input logic [SIZE_CODE_W-1:0] c);
    return int'(c) <= SIZE_CODE_MAX;
  endfunction
endpackage

// File: rtl/awd_range_cmp.sv
module awd_range_cmp #(
  parameter int KEY_W = 12
) (
  input  logic [KEY_W-1:0] base,
  input  logic [KEY_W-1:0] limit,
  input  logic [KEY_W-1:0] key,
  output logic             win_on,
  output logic             hit
);
  always_comb begin
    win_on = (base <= limit);
    hit    = win_on && (key >= base) && (key <= limit);
  end
endmodule

// File: rtl/awd_aper_cmp.sv
module awd_aper_cmp
  import awd_pkg::*;
#(
  parameter int KEY_W  = APER_KEY_W,
  parameter int CODE_W = SIZE_CODE_W
) (
  input  logic [KEY_W-1:0]  base,
  input  logic [CODE_W-1:0] code,
  input  logic [KEY_W-1:0]  key,
  output logic              hit
);
  logic [KEY_W-1:0] keep;
  always_comb begin
    keep = aper_keep_mask(code);
    hit  = ((key ^ base) & keep) == '0;
  end
endmodule

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
  import awd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [DATA_W-1:0]      rd_data,
  output logic [MEM_KEY_W-1:0]   mem_base  [N_MEM_WIN],
  output logic [MEM_KEY_W-1:0]   mem_limit [N_MEM_WIN],
  output logic [IO_KEY_W-1:0]    io_base,
  output logic [IO_KEY_W-1:0]    io_limit,
  output logic [APER_KEY_W-1:0]  aper_base,
  output logic [SIZE_CODE_W-1:0] aper_code,
  output logic                   port_en,
  output logic                   sb_en,
  output logic [RATE_W-1:0]      rate
);
  localparam int MEM_BASE_LSB  = 0;
  localparam int MEM_LIM_LSB   = 16;
  localparam int IO_BASE_LSB   = 0;
  localparam int IO_LIM_LSB    = 8;
  localparam int APER_BASE_LSB = ADDR_W - APER_KEY_W;
  localparam int EN_BIT        = 8;
  localparam int SB_BIT        = 9;
  localparam logic [RATE_W-1:0] RATE_RST = 2'b01;

  logic unused_wd;
  assign unused_wd = ^wr_data[15:12];

  // Decoded write events, brought out for the checks below.
  logic wr_ctrl, wr_io, wr_aper, rate_take, code_take;
  logic [N_MEM_WIN-1:0] wr_mem;
  logic [RATE_W-1:0]      wd_rate;
  logic [SIZE_CODE_W-1:0] wd_code;

  always_comb begin
    wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    wr_io     = wr_en && (wr_sel == SEL_IO);
    wr_aper   = wr_en && (wr_sel == SEL_APER);
    wr_mem[0] = wr_en && (wr_sel == SEL_MEM);
    wr_mem[1] = wr_en && (wr_sel == SEL_PMEM);
    wd_rate   = wr_data[RATE_W-1:0];
    wd_code   = wr_data[SIZE_CODE_W-1:0];
    rate_take = wr_ctrl && rate_valid(wd_rate);
    code_take = wr_aper && size_code_valid(wd_code);
  end

  for (genvar g = 0; g < N_MEM_WIN; g++) begin : g_mem
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_base[g]  <= '1;
        mem_limit[g] <= '0;
      end else if (wr_mem[g]) begin
        mem_base[g]  <= wr_data[MEM_BASE_LSB +: MEM_KEY_W];
        mem_limit[g] <= wr_data[MEM_LIM_LSB  +: MEM_KEY_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_base  <= '1;
      io_limit <= '0;
    end else if (wr_io) begin
      io_base  <= wr_data[IO_BASE_LSB +: IO_KEY_W];
      io_limit <= wr_data[IO_LIM_LSB  +: IO_KEY_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aper_base <= '1;
      aper_code <= '0;
    end else begin
      if (wr_aper)   aper_base <= wr_data[APER_BASE_LSB +: APER_KEY_W];
      if (code_take) aper_code <= wd_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_en <= 1'b0;
      sb_en   <= 1'b0;
      rate    <= RATE_RST;
    end else begin
      if (wr_ctrl) begin
        port_en <= wr_data[EN_BIT];
        sb_en   <= wr_data[SB_BIT];
      end
      if (rate_take) rate <= wd_rate;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: begin
        rd_data[RATE_W-1:0] = rate;
        rd_data[EN_BIT]     = port_en;
        rd_data[SB_BIT]     = sb_en;
      end
      SEL_MEM, SEL_PMEM: begin
        rd_data[MEM_BASE_LSB +: MEM_KEY_W] = mem_base[(rd_sel == SEL_PMEM) ? 1 : 0];
        rd_data[MEM_LIM_LSB  +: MEM_KEY_W] = mem_limit[(rd_sel == SEL_PMEM) ? 1 : 0];
      end
      SEL_IO: begin
        rd_data[IO_BASE_LSB +: IO_KEY_W] = io_base;
        rd_data[IO_LIM_LSB  +: IO_KEY_W] = io_limit;
      end
      SEL_APER: begin
        rd_data[APER_BASE_LSB +: APER_KEY_W] = aper_base;
        rd_data[SIZE_CODE_W-1:0]             = aper_code;
      end
      default: rd_data = '0;
    endcase
  end

  // R8
  rate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rate) == 1);
  // R9
  rate_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !rate_valid(wd_rate)) |=> $stable(rate));
  // R6
  code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aper && !size_code_valid(wd_code)) |=> $stable(aper_code));
  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(aper_code) <= SIZE_CODE_MAX);
  // R8
  ctrl_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_CTRL) |-> (rd_data[31:10] == '0 && rd_data[7:2] == '0));
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_wsel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsel,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_vld,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              svc_done,
  output logic              hit_mem,
  output logic              hit_pmem,
  output logic              hit_io,
  output logic              hit_aper,
  output logic              fwd_gfx,
  output logic              op_pend
);
  localparam int MEM_KEY_LSB  = ADDR_W - MEM_KEY_W;
  localparam int IO_KEY_LSB   = IO_SPACE_W - IO_KEY_W;
  localparam int APER_KEY_LSB = ADDR_W - APER_KEY_W;

  logic [MEM_KEY_W-1:0]   mem_base  [N_MEM_WIN];
  logic [MEM_KEY_W-1:0]   mem_limit [N_MEM_WIN];
  logic [IO_KEY_W-1:0]    io_base, io_limit;
  logic [APER_KEY_W-1:0]  aper_base;
  logic [SIZE_CODE_W-1:0] aper_code;
  logic                   port_en, sb_en;
  logic [RATE_W-1:0]      rate;

  logic unused_top;
  assign unused_top = ^{req_addr[19:16], req_addr[11:0], sb_en, rate};

  awd_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_wsel),
    .wr_data   (cfg_wdata),
    .rd_sel    (cfg_rsel),
    .rd_data   (cfg_rdata),
    .mem_base  (mem_base),
    .mem_limit (mem_limit),
    .io_base   (io_base),
    .io_limit  (io_limit),
    .aper_base (aper_base),
    .aper_code (aper_code),
    .port_en   (port_en),
    .sb_en     (sb_en),
    .rate      (rate)
  );

  logic [N_MEM_WIN-1:0] mem_on, mem_raw;
  logic                 io_on, io_raw, aper_raw;

  for (genvar g = 0; g < N_MEM_WIN; g++) begin : g_memcmp
    awd_range_cmp #(.KEY_W(MEM_KEY_W)) u_cmp (
      .base   (mem_base[g]),
      .limit  (mem_limit[g]),
      .key    (req_addr[MEM_KEY_LSB +: MEM_KEY_W]),
      .win_on (mem_on[g]),
      .hit    (mem_raw[g])
    );
  end

  awd_range_cmp #(.KEY_W(IO_KEY_W)) u_iocmp (
    .base   (io_base),
    .limit  (io_limit),
    .key    (req_addr[IO_KEY_LSB +: IO_KEY_W]),
    .win_on (io_on),
    .hit    (io_raw)
  );

  awd_aper_cmp u_apcmp (
    .base (aper_base),
    .code (aper_code),
    .key  (req_addr[APER_KEY_LSB +: APER_KEY_W]),
    .hit  (aper_raw)
  );

  // Classified request events.
  logic dec_mem, dec_pmem, dec_io, dec_aper, any_hit, accept;
  always_comb begin
    dec_mem  = req_vld && !req_is_io && mem_raw[0];
    dec_pmem = req_vld && !req_is_io && mem_raw[1];
    dec_aper = req_vld && !req_is_io && aper_raw;
    dec_io   = req_vld &&  req_is_io && io_raw;
    any_hit  = dec_mem || dec_pmem || dec_aper || dec_io;
    accept   = any_hit && port_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_mem  <= 1'b0;
      hit_pmem <= 1'b0;
      hit_io   <= 1'b0;
      hit_aper <= 1'b0;
      fwd_gfx  <= 1'b0;
      op_pend  <= 1'b0;
    end else begin
      hit_mem  <= dec_mem;
      hit_pmem <= dec_pmem;
      hit_io   <= dec_io;
      hit_aper <= dec_aper;
      fwd_gfx  <= accept;
      if (accept)        op_pend <= 1'b1;
      else if (svc_done) op_pend <= 1'b0;
    end
  end

  // R7
  hit_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mem || hit_pmem || hit_io || hit_aper) |-> $past(req_vld));
  // R7
  space_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_io |-> !(hit_mem || hit_pmem || hit_aper));
  // R4
  mem_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mem |-> $past(mem_on[0]));
  // R4
  io_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_io |-> $past(io_on));
  // R10
  fwd_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_gfx |-> $past(port_en));
  // R11
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pend && !svc_done) |=> op_pend);
  // R11
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> op_pend);
endmodule

// File: tb/addr_win_decoder_bench.sv
module addr_win_decoder_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wsel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_rsel = '0;
  logic [31:0] cfg_rdata;
  logic        req_vld = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic        svc_done = 1'b0;
  logic        hit_mem, hit_pmem, hit_io, hit_aper, fwd_gfx, op_pend;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_win_decoder u_addr_win_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .req_vld(req_vld), .req_is_io(req_is_io), .req_addr(req_addr),
    .svc_done(svc_done), .hit_mem(hit_mem), .hit_pmem(hit_pmem),
    .hit_io(hit_io), .hit_aper(hit_aper), .fwd_gfx(fwd_gfx), .op_pend(op_pend)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfg_rsel = sel;
    #1 data = cfg_rdata;
  endtask

  // Returns {hit_mem, hit_pmem, hit_io, hit_aper, fwd_gfx} for one request.
  task automatic probe(input logic [31:0] addr, input logic io,
                       input logic done_in, output logic [4:0] res);
    @(negedge clk);
    req_vld = 1'b1; req_addr = addr; req_is_io = io; svc_done = done_in;
    @(negedge clk);
    req_vld = 1'b0; svc_done = 1'b0;
    res = {hit_mem, hit_pmem, hit_io, hit_aper, fwd_gfx};
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [4:0]  r;
    chk("R11", "pend after reset", {31'b0, op_pend}, 32'h0);
    rd(3'd0, d); chk("R8", "ctrl reset", d, 32'h0000_0001);
    rd(3'd1, d); chk("R1", "mem reset", d, 32'h0000_0FFF);
    rd(3'd3, d); chk("R3", "io reset", d, 32'h0000_000F);
    rd(3'd4, d); chk("R5", "aper reset", d, 32'hFFC0_0000);
    rd(3'd6, d); chk("R8", "unused select", d, 32'h0);
    probe(32'hFFF0_0000, 1'b0, 1'b0, r);
    chk("R4", "reset windows off, aperture top 4MB", {27'b0, r}, {27'b0, 5'b00010});
    probe(32'h0000_0000, 1'b0, 1'b0, r);
    chk("R4", "reset mem at 0 misses", {27'b0, r}, 32'h0);
  endtask

  task automatic t_mem;
    logic [4:0] r;
    wr(3'd1, 32'h010F_0100);
    probe(32'h1000_0000, 1'b0, 1'b0, r); chk("R1", "mem low edge", {27'b0, r}, {27'b0, 5'b10000});
    probe(32'h10FF_FFFF, 1'b0, 1'b0, r); chk("R1", "mem high edge", {27'b0, r}, {27'b0, 5'b10000});
    probe(32'h0FFF_FFFF, 1'b0, 1'b0, r); chk("R1", "mem below", {27'b0, r}, 32'h0);
    probe(32'h1100_0000, 1'b0, 1'b0, r); chk("R1", "mem above", {27'b0, r}, 32'h0);
    probe(32'h1000_0000, 1'b1, 1'b0, r); chk("R7", "io request ignores mem", {27'b0, r}, 32'h0);
    @(negedge clk);
    chk("R7", "no strobe no hit", {31'b0, hit_mem}, 32'h0);
  endtask

  task automatic t_pmem;
    logic [4:0] r;
    wr(3'd2, 32'h0020_0020);
    probe(32'h020F_FFFF, 1'b0, 1'b0, r); chk("R2", "pmem single MB top", {27'b0, r}, {27'b0, 5'b01000});
    probe(32'h0200_0000, 1'b0, 1'b0, r); chk("R2", "pmem single MB base", {27'b0, r}, {27'b0, 5'b01000});
    probe(32'h0210_0000, 1'b0, 1'b0, r); chk("R2", "pmem above", {27'b0, r}, 32'h0);
  endtask

  task automatic t_io;
    logic [4:0] r;
    wr(3'd3, 32'h0000_0503);
    probe(32'h0000_3000, 1'b1, 1'b0, r); chk("R3", "io low edge", {27'b0, r}, {27'b0, 5'b00100});
    probe(32'h0000_5FFF, 1'b1, 1'b0, r); chk("R3", "io high edge", {27'b0, r}, {27'b0, 5'b00100});
    probe(32'h0000_2FFF, 1'b1, 1'b0, r); chk("R3", "io below", {27'b0, r}, 32'h0);
    probe(32'h0000_6000, 1'b1, 1'b0, r); chk("R3", "io above", {27'b0, r}, 32'h0);
    probe(32'h0000_4000, 1'b0, 1'b0, r); chk("R7", "mem request ignores io", {27'b0, r}, 32'h0);
  endtask

  task automatic t_disabled;
    logic [4:0] r;
    wr(3'd1, 32'h01FF_0200);
    probe(32'h1FF0_0000, 1'b0, 1'b0, r); chk("R4", "inverted mem at limit", {27'b0, r}, 32'h0);
    probe(32'h2000_0000, 1'b0, 1'b0, r); chk("R4", "inverted mem at base", {27'b0, r}, 32'h0);
    wr(3'd3, 32'h0000_0104);
    probe(32'h0000_4000, 1'b1, 1'b0, r); chk("R4", "inverted io", {27'b0, r}, 32'h0);
    wr(3'd3, 32'h0000_0503);
  endtask

  task automatic t_aper;
    logic [4:0]  r;
    logic [31:0] d;
    wr(3'd4, 32'h8000_0002);
    probe(32'h80FF_FFFF, 1'b0, 1'b0, r); chk("R5", "16MB top", {27'b0, r}, {27'b0, 5'b00010});
    probe(32'h8100_0000, 1'b0, 1'b0, r); chk("R5", "16MB above", {27'b0, r}, 32'h0);
    probe(32'h7FFF_FFFF, 1'b0, 1'b0, r); chk("R5", "16MB below", {27'b0, r}, 32'h0);
    wr(3'd4, 32'h9400_0006);
    probe(32'h9000_0000, 1'b0, 1'b0, r); chk("R5", "256MB bottom", {27'b0, r}, {27'b0, 5'b00010});
    probe(32'h9FFF_FFFF, 1'b0, 1'b0, r); chk("R5", "256MB top", {27'b0, r}, {27'b0, 5'b00010});
    probe(32'hA000_0000, 1'b0, 1'b0, r); chk("R5", "256MB above", {27'b0, r}, 32'h0);
    probe(32'h9000_0000, 1'b1, 1'b0, r); chk("R7", "io ignores aperture", {27'b0, r}, 32'h0);
    wr(3'd4, 32'h8000_0007);
    rd(3'd4, d); chk("R6", "code 7 keeps size", d, 32'h8000_0006);
    probe(32'h8F00_0000, 1'b0, 1'b0, r); chk("R6", "256MB kept after bad code", {27'b0, r}, {27'b0, 5'b00010});
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, d); chk("R8", "ctrl full write", d, 32'h0000_0302);
    wr(3'd0, 32'h0000_0003);
    rd(3'd0, d); chk("R9", "rate 11 ignored", d, 32'h0000_0002);
    wr(3'd0, 32'h0000_0100);
    rd(3'd0, d); chk("R9", "rate 00 ignored", d, 32'h0000_0102);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, d); chk("R8", "rate 1x", d, 32'h0000_0001);
  endtask

  task automatic t_fwd;
    logic [4:0] r;
    wr(3'd0, 32'h0000_0101);
    probe(32'h0000_4000, 1'b1, 1'b1, r); chk("R10", "enabled hit forwards", {27'b0, r}, {27'b0, 5'b00101});
    probe(32'h0000_7000, 1'b1, 1'b1, r); chk("R10", "enabled miss", {27'b0, r}, 32'h0);
    wr(3'd0, 32'h0000_0001);
    probe(32'h0000_4000, 1'b1, 1'b0, r); chk("R10", "disabled hit not forwarded", {27'b0, r}, {27'b0, 5'b00100});
  endtask

  task automatic t_pending;
    logic [4:0] r;
    @(negedge clk); svc_done = 1'b1; @(negedge clk); svc_done = 1'b0;
    chk("R11", "cleared before test", {31'b0, op_pend}, 32'h0);
    wr(3'd0, 32'h0000_0101);
    probe(32'h0000_4000, 1'b1, 1'b0, r);
    chk("R11", "set by forward", {31'b0, op_pend}, 32'h1);
    wr(3'd0, 32'h0000_0001);
    chk("R11", "kept after disable", {31'b0, op_pend}, 32'h1);
    probe(32'h0000_4000, 1'b1, 1'b0, r);
    chk("R11", "disabled hit keeps pend, no fwd", {30'b0, op_pend, r[0]}, 32'h2);
    @(negedge clk); svc_done = 1'b1; @(negedge clk); svc_done = 1'b0;
    chk("R11", "cleared by done", {31'b0, op_pend}, 32'h0);
    probe(32'h0000_4000, 1'b1, 1'b0, r);
    chk("R11", "disabled request does not set", {31'b0, op_pend}, 32'h0);
    wr(3'd0, 32'h0000_0101);
    probe(32'h0000_4000, 1'b1, 1'b1, r);
    chk("R11", "set wins over done", {31'b0, op_pend}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem();
    t_pmem();
    t_io();
    t_disabled();
    t_aper();
    t_ctrl();
    t_fwd();
    t_pending();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule